// File: doc/BRIEF.md
# Frequent-Pattern Cache Line Codec

This block shrinks a 64-byte cache line (sixteen 32-bit words) and restores it. The encoder looks at each word separately and tests it against seven value shapes that occur often in memory: a zero word, small sign-extended values, a half-word with a zero low half, a pair of small half-words, and a word made of one repeated byte. Each word gets a 3-bit class code. Any bits the shape leaves unfixed go into a densely packed payload. The encoder also reports the total compressed size in 64-bit segments. A line that would not fit in the space of the raw line is flagged and passed through unchanged.

The expander is a separate stream path. It takes a code field, a payload and the raw flag, and rebuilds the original line through five pipeline registers. Both paths use valid/ready. A beat transfers on a rising edge where valid and ready are both high. A producer must hold its data stable while valid is high and ready is low. Each path takes a new beat in any cycle where its output register is empty or is being drained in that same cycle. When an output is stalled, that path drops its input ready, and the whole expander pipeline freezes in place.

Top module: `fpc_line_codec`

## Requirements
- R1: An all-zero word gets class 0 and adds no payload bits. An all-zero line reports 1 segment, all codes 0 and an all-zero payload.
- R2: Each word gets the class with the smallest payload that reproduces it. A tie goes to the lower class number. The classes are: 0 zero (0 bits); 1 signed 4-bit (4); 2 signed 8-bit (8); 3 signed 16-bit (16); 4 high half-word with a zero low half (16); 5 two halves, each a signed 8-bit value (16); 6 one byte repeated four times (8); 7 raw word (32).
- R3: The code of word i sits in `cout_prefix[3i+2:3i]`. Payload fields are packed LSB-first from bit 0, starting with word 0. The fields are: class 1 the low 4 bits; class 2 the low byte; class 3 the low half; class 4 the high half; class 5 {byte 2, byte 0}; class 6 byte 0; class 7 the whole word.
- R4: `cout_segs` equals ceil((48 + payload bits) / 64).
- R5: If that count exceeds 8, `cout_raw` is 1, `cout_segs` is 8, every code is 7 and the payload is the raw line.
- R6: `cin_ready` is high when the output register is empty or is being drained in that cycle. An accepted line appears on the output after one rising edge.
- R7: While `cout_valid` is high and `cout_ready` is low, every compressed output field is held stable.
- R8: The expander rebuilds the exact original line from the code field, the payload and the raw flag.
- R9: With `dout_ready` held high, a beat accepted on `din` is presented on `dout` after the fifth rising edge, counting the accepting edge.
- R10: While `dout_valid` is high and `dout_ready` is low, `dout_line` is held stable and `din_ready` is low.
- R11: During reset, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cin_valid | input | 1 | Line to compress is valid |
| cin_ready | output | 1 | Encoder can take a line |
| cin_line | input | 512 | Line to compress, word i in bits [32i+31:32i] |
| cout_valid | output | 1 | Compressed result valid |
| cout_ready | input | 1 | Consumer takes the compressed result |
| cout_prefix | output | 48 | Per-word 3-bit class codes |
| cout_payload | output | 512 | Packed payload |
| cout_segs | output | 4 | Size in 64-bit segments |
| cout_raw | output | 1 | Line stored uncompressed |
| din_valid | input | 1 | Compressed beat to expand is valid |
| din_ready | output | 1 | Expander can take a beat |
| din_prefix | input | 48 | Class codes to expand |
| din_payload | input | 512 | Packed payload to expand |
| din_raw | input | 1 | Beat holds a raw line |
| dout_valid | output | 1 | Rebuilt line valid |
| dout_ready | input | 1 | Consumer takes the rebuilt line |
| dout_line | output | 512 | Rebuilt line |

## Verification
The encoder result is due one rising edge after the line is accepted. The bench drives inputs on falling edges and reads the code field, payload, segment count and raw flag at the next falling edge. The expanded line is due on the fifth rising edge, counting the one that accepts the beat. The bench counts falling edges from acceptance until `dout_valid` goes high, then checks both the count and the line. For the stall cases, the bench holds ready low for several cycles and re-reads the outputs and the opposite ready at each falling edge before it releases the stall.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    FPC_ZERO = 3'd0,
    FPC_SE4  = 3'd1,
    FPC_SE8  = 3'd2,
    FPC_SE16 = 3'd3,
    FPC_HPAD = 3'd4,
    FPC_TWOH = 3'd5,
    FPC_REPB = 3'd6,
    FPC_RAW  = 3'd7
  } fpc_code_e;

  // Priority follows payload size, lower code first on equal size.
  function automatic fpc_code_e fpc_classify(input logic [31:0] w);
    logic is_se4, is_se8, is_se16, is_rep, is_pad, is_two;
    is_se4  = (w[31:3]  == {29{w[3]}});
    is_se8  = (w[31:7]  == {25{w[7]}});
    is_se16 = (w[31:15] == {17{w[15]}});
    is_rep  = (w[31:24] == w[7:0]) && (w[23:16] == w[7:0]) && (w[15:8] == w[7:0]);
    is_pad  = (w[15:0] == 16'h0000);
    is_two  = (w[31:23] == {9{w[23]}}) && (w[15:7] == {9{w[7]}});
    if (w == 32'h0)   return FPC_ZERO;
    else if (is_se4)  return FPC_SE4;
    else if (is_se8)  return FPC_SE8;
    else if (is_rep)  return FPC_REPB;
    else if (is_se16) return FPC_SE16;
    else if (is_pad)  return FPC_HPAD;
    else if (is_two)  return FPC_TWOH;
    else              return FPC_RAW;
  endfunction

  function automatic logic [5:0] fpc_len(input fpc_code_e c);
    case (c)
      FPC_ZERO: return 6'd0;
      FPC_SE4:  return 6'd4;
      FPC_SE8, FPC_REPB: return 6'd8;
      FPC_SE16, FPC_HPAD, FPC_TWOH: return 6'd16;
      default:  return 6'd32;
    endcase
  endfunction

  function automatic logic [31:0] fpc_field(input logic [31:0] w, input fpc_code_e c);
    case (c)
      FPC_ZERO: return 32'h0;
      FPC_SE4:  return {28'h0, w[3:0]};
      FPC_SE8, FPC_REPB: return {24'h0, w[7:0]};
      FPC_SE16: return {16'h0, w[15:0]};
      FPC_HPAD: return {16'h0, w[31:16]};
      FPC_TWOH: return {16'h0, w[23:16], w[7:0]};
      default:  return w;
    endcase
  endfunction

  function automatic logic [31:0] fpc_expand(input logic [31:0] f, input fpc_code_e c);
    case (c)
      FPC_ZERO: return 32'h0;
      FPC_SE4:  return {{28{f[3]}}, f[3:0]};
      FPC_SE8:  return {{24{f[7]}}, f[7:0]};
      FPC_SE16: return {{16{f[15]}}, f[15:0]};
      FPC_HPAD: return {f[15:0], 16'h0000};
      FPC_TWOH: return {{8{f[15]}}, f[15:8], {8{f[7]}}, f[7:0]};
      FPC_REPB: return {4{f[7:0]}};
      default:  return f;
    endcase
  endfunction

endpackage

// File: rtl/fpc_word_enc.sv
module fpc_word_enc
  import fpc_pkg::*;
(
  input  logic [31:0] word,
  output logic [2:0]  code,
  output logic [5:0]  len,
  output logic [31:0] field
);
  fpc_code_e c;
  always_comb begin
    c     = fpc_classify(word);
    code  = c;
    len   = fpc_len(c);
    field = fpc_field(word, c);
  end
endmodule

// File: rtl/fpc_compressor.sv
module fpc_compressor #(
  parameter int WORDS = 16,
  parameter int SEG_W = 64,
  localparam int LINE_W   = WORDS * 32,
  localparam int PFX_W    = WORDS * 3,
  localparam int TOT_W    = $clog2(PFX_W + LINE_W + 1),
  localparam int RAW_SEGS = LINE_W / SEG_W,
  localparam int SEGS_W   = $clog2((PFX_W + LINE_W + SEG_W - 1) / SEG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LINE_W-1:0] in_line,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PFX_W-1:0]  out_prefix,
  output logic [LINE_W-1:0] out_payload,
  output logic [SEGS_W-1:0] out_segs,
  output logic              out_raw
);
  logic [WORDS-1:0][2:0]  code;
  logic [WORDS-1:0][5:0]  len;
  logic [WORDS-1:0][31:0] field;

  for (genvar i = 0; i < WORDS; i++) begin : g_enc
    fpc_word_enc u_enc (
      .word (in_line[32*i +: 32]),
      .code (code[i]),
      .len  (len[i]),
      .field(field[i])
    );
  end

  logic [TOT_W-1:0]  off;
  logic [TOT_W-1:0]  total;
  logic [TOT_W-1:0]  nseg;
  logic [LINE_W-1:0] pk;
  logic [PFX_W-1:0]  pfx;
  logic              raw;

  always_comb begin
    off = '0;
    pk  = '0;
    pfx = '0;
    for (int i = 0; i < WORDS; i++) begin
      pk  = pk | (LINE_W'(field[i]) << off);
      off = off + TOT_W'(len[i]);
      pfx[3*i +: 3] = code[i];
    end
    total = TOT_W'(PFX_W) + off;
    nseg  = (total + TOT_W'(SEG_W - 1)) / TOT_W'(SEG_W);
    raw   = nseg > TOT_W'(RAW_SEGS);
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_prefix  <= '0;
      out_payload <= '0;
      out_segs    <= '0;
      out_raw     <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_raw     <= raw;
      out_prefix  <= raw ? '1 : pfx;
      out_payload <= raw ? in_line : pk;
      out_segs    <= raw ? SEGS_W'(RAW_SEGS) : SEGS_W'(nseg);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/fpc_decompressor.sv
module fpc_decompressor
  import fpc_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int LINE_W = WORDS * 32,
  localparam int PFX_W  = WORDS * 3,
  localparam int OFF_W  = $clog2(LINE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PFX_W-1:0]  in_prefix,
  input  logic [LINE_W-1:0] in_payload,
  input  logic              in_raw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_line
);
  // Stage valids; whole pipe advances together when the last stage can move.
  logic [4:0] v;
  logic       adv;
  assign adv      = !v[4] || out_ready;
  assign in_ready = adv;
  assign out_valid = v[4];

  // Stage 1: capture, force raw codes
  logic [WORDS-1:0][2:0]  s1_code;
  logic [LINE_W-1:0]      s1_pl;
  // Stage 2: offsets
  logic [WORDS-1:0][2:0]  s2_code;
  logic [WORDS-1:0][OFF_W-1:0] s2_off;
  logic [LINE_W-1:0]      s2_pl;
  // Stage 3: fields
  logic [WORDS-1:0][2:0]  s3_code;
  logic [WORDS-1:0][31:0] s3_fld;
  // Stage 4: expanded words
  logic [LINE_W-1:0]      s4_line;

  logic [WORDS-1:0][OFF_W-1:0] off_c;
  logic [WORDS-1:0][31:0]      fld_c;
  logic [LINE_W-1:0]           line_c;

  always_comb begin
    logic [OFF_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < WORDS; i++) begin
      off_c[i] = acc;
      acc = acc + OFF_W'(fpc_len(fpc_code_e'(s1_code[i])));
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign fld_c[i] = 32'(s2_pl >> s2_off[i]);
    assign line_c[32*i +: 32] = fpc_expand(s3_fld[i], fpc_code_e'(s3_code[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0;
      s1_code <= '0; s1_pl <= '0;
      s2_code <= '0; s2_off <= '0; s2_pl <= '0;
      s3_code <= '0; s3_fld <= '0;
      s4_line <= '0; out_line <= '0;
    end else if (adv) begin
      v <= {v[3:0], in_valid};
      for (int i = 0; i < WORDS; i++)
        s1_code[i] <= in_raw ? 3'd7 : in_prefix[3*i +: 3];
      s1_pl    <= in_payload;
      s2_code  <= s1_code;
      s2_off   <= off_c;
      s2_pl    <= s1_pl;
      s3_code  <= s2_code;
      s3_fld   <= fld_c;
      s4_line  <= line_c;
      out_line <= s4_line;
    end
  end
endmodule

// File: rtl/fpc_line_codec.sv
module fpc_line_codec #(
  parameter int WORDS = 16,
  parameter int SEG_W = 64,
  localparam int LINE_W = WORDS * 32,
  localparam int PFX_W  = WORDS * 3,
  localparam int SEGS_W = $clog2((PFX_W + LINE_W + SEG_W - 1) / SEG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cin_valid,
  output logic              cin_ready,
  input  logic [LINE_W-1:0] cin_line,
  output logic              cout_valid,
  input  logic              cout_ready,
  output logic [PFX_W-1:0]  cout_prefix,
  output logic [LINE_W-1:0] cout_payload,
  output logic [SEGS_W-1:0] cout_segs,
  output logic              cout_raw,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [PFX_W-1:0]  din_prefix,
  input  logic [LINE_W-1:0] din_payload,
  input  logic              din_raw,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [LINE_W-1:0] dout_line
);
  fpc_compressor #(.WORDS(WORDS), .SEG_W(SEG_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cin_valid), .in_ready(cin_ready), .in_line(cin_line),
    .out_valid(cout_valid), .out_ready(cout_ready),
    .out_prefix(cout_prefix), .out_payload(cout_payload),
    .out_segs(cout_segs), .out_raw(cout_raw)
  );

  fpc_decompressor #(.WORDS(WORDS)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(din_valid), .in_ready(din_ready),
    .in_prefix(din_prefix), .in_payload(din_payload), .in_raw(din_raw),
    .out_valid(dout_valid), .out_ready(dout_ready), .out_line(dout_line)
  );
endmodule

// File: rtl/fpc_codec_checker.sv
module fpc_codec_checker #(
  parameter int WORDS = 16,
  parameter int SEG_W = 64,
  localparam int LINE_W   = WORDS * 32,
  localparam int PFX_W    = WORDS * 3,
  localparam int RAW_SEGS = LINE_W / SEG_W,
  localparam int SEGS_W   = $clog2((PFX_W + LINE_W + SEG_W - 1) / SEG_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cin_valid,
  input logic              cin_ready,
  input logic              cout_valid,
  input logic              cout_ready,
  input logic [PFX_W-1:0]  cout_prefix,
  input logic [LINE_W-1:0] cout_payload,
  input logic [SEGS_W-1:0] cout_segs,
  input logic              cout_raw,
  input logic              din_ready,
  input logic              dout_valid,
  input logic              dout_ready,
  input logic [LINE_W-1:0] dout_line
);
  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (!cout_valid && !dout_valid));

  assert_accept_to_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_valid && cin_ready) |=> cout_valid);

  assert_cin_backpress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && !cout_ready) |-> !cin_ready);

  assert_cout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && !cout_ready) |=> (cout_valid && $stable(cout_prefix) &&
      $stable(cout_payload) && $stable(cout_segs) && $stable(cout_raw)));

  assert_segs_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cout_valid |-> (cout_segs >= SEGS_W'(1) && cout_segs <= SEGS_W'(RAW_SEGS)));

  assert_raw_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && cout_raw) |-> (cout_segs == SEGS_W'(RAW_SEGS) && &cout_prefix));

  assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_line)));

  assert_din_backpress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |-> !din_ready);
endmodule

bind fpc_line_codec fpc_codec_checker #(.WORDS(WORDS), .SEG_W(SEG_W)) u_fpc_chk (
  .clk(clk), .rst_n(rst_n),
  .cin_valid(cin_valid), .cin_ready(cin_ready),
  .cout_valid(cout_valid), .cout_ready(cout_ready),
  .cout_prefix(cout_prefix), .cout_payload(cout_payload),
  .cout_segs(cout_segs), .cout_raw(cout_raw),
  .din_ready(din_ready), .dout_valid(dout_valid),
  .dout_ready(dout_ready), .dout_line(dout_line)
);

// File: tb/test_fpc_line_codec.sv
module test_fpc_line_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         cin_valid = 0, cout_ready = 1, din_valid = 0, din_raw = 0, dout_ready = 1;
  logic [511:0] cin_line = '0, din_payload = '0;
  logic [47:0]  din_prefix = '0;
  logic         cin_ready, cout_valid, cout_raw, din_ready, dout_valid;
  logic [47:0]  cout_prefix;
  logic [511:0] cout_payload, dout_line;
  logic [3:0]   cout_segs;

  fpc_line_codec i_fpc_line_codec (
    .clk(clk), .rst_n(rst_n),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_line(cin_line),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_prefix(cout_prefix),
    .cout_payload(cout_payload), .cout_segs(cout_segs), .cout_raw(cout_raw),
    .din_valid(din_valid), .din_ready(din_ready), .din_prefix(din_prefix),
    .din_payload(din_payload), .din_raw(din_raw),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_line(dout_line)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [575:0] act, input logic [575:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference classification written from the requirement table.
  function automatic int m_code(input logic [31:0] w);
    int s; int hi; int lo;
    s  = $signed(w);
    hi = $signed(w[31:16]);
    lo = $signed(w[15:0]);
    if (w == 0) return 0;
    if (s >= -8 && s <= 7) return 1;
    if (s >= -128 && s <= 127) return 2;
    if (w == {4{w[7:0]}}) return 6;
    if (s >= -32768 && s <= 32767) return 3;
    if (w[15:0] == 16'h0) return 4;
    if (hi >= -128 && hi <= 127 && lo >= -128 && lo <= 127) return 5;
    return 7;
  endfunction

  function automatic int m_len(input int c);
    int t [8] = '{0, 4, 8, 16, 16, 16, 8, 32};
    return t[c];
  endfunction

  function automatic logic [31:0] m_field(input logic [31:0] w, input int c);
    case (c)
      1: return 32'(w[3:0]);
      2, 6: return 32'(w[7:0]);
      3: return 32'(w[15:0]);
      4: return 32'(w[31:16]);
      5: return 32'({w[23:16], w[7:0]});
      7: return w;
      default: return 32'h0;
    endcase
  endfunction

  logic [47:0]  e_pfx;
  logic [511:0] e_pl;
  logic [3:0]   e_segs;
  logic         e_raw;

  task automatic model(input logic [511:0] line);
    int pos = 0;
    e_pfx = '0; e_pl = '0;
    for (int i = 0; i < 16; i++) begin
      int c = m_code(line[32*i +: 32]);
      logic [31:0] f = m_field(line[32*i +: 32], c);
      e_pfx[3*i +: 3] = 3'(c);
      for (int b = 0; b < m_len(c); b++) begin
        if (pos < 512) e_pl[pos] = f[b];
        pos++;
      end
    end
    e_segs = 4'((48 + pos + 63) / 64);
    e_raw  = (48 + pos + 63) / 64 > 8;
    if (e_raw) begin e_pfx = '1; e_pl = line; e_segs = 4'd8; end
  endtask

  logic [47:0]  c_pfx;
  logic [511:0] c_pl;
  logic         c_raw;

  // Compress one line, check encoder outputs; optionally stall the output.
  task automatic do_compress(input logic [511:0] line, input string tag, input int stall);
    model(line);
    @(negedge clk);
    cin_line = line; cin_valid = 1; cout_ready = 1;
    chk({"R6 cin_ready idle ", tag}, 576'(cin_ready), 576'(1));
    @(negedge clk);
    cin_valid = 0;
    chk({"R6 one-edge latency ", tag}, 576'(cout_valid), 576'(1));
    chk({"R2 class codes ", tag}, 576'(cout_prefix), 576'(e_pfx));
    chk({"R3 packed payload ", tag}, 576'(cout_payload), 576'(e_pl));
    chk({"R4 segments ", tag}, 576'(cout_segs), 576'(e_segs));
    chk({"R5 raw flag ", tag}, 576'(cout_raw), 576'(e_raw));
    c_pfx = cout_prefix; c_pl = cout_payload; c_raw = cout_raw;
    if (stall > 0) begin
      cout_ready = 0;
      repeat (stall) begin
        @(negedge clk);
        chk("R7 held valid", 576'(cout_valid), 576'(1));
        chk("R7 held payload", 576'(cout_payload), 576'(c_pl));
        chk("R7 held prefix", 576'(cout_prefix), 576'(c_pfx));
        chk("R6 ready low when stalled", 576'(cin_ready), 576'(0));
      end
      cout_ready = 1;
    end
  endtask

  task automatic do_expand(input logic [511:0] line, input string tag);
    int n;
    @(negedge clk);
    din_prefix = c_pfx; din_payload = c_pl; din_raw = c_raw; din_valid = 1; dout_ready = 1;
    chk({"R9 din_ready idle ", tag}, 576'(din_ready), 576'(1));
    @(negedge clk);
    din_valid = 0;
    n = 1;
    while (!dout_valid && n < 20) begin @(negedge clk); n++; end
    chk({"R9 expand latency ", tag}, 576'(n), 576'(5));
    chk({"R8 round trip ", tag}, 576'(dout_line), 576'(line));
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] r = $urandom;
    case ($urandom % 8)
      0: return 32'h0;
      1: return {{28{r[3]}}, r[3:0]};
      2: return {{24{r[7]}}, r[7:0]};
      3: return {{16{r[15]}}, r[15:0]};
      4: return {r[31:16], 16'h0};
      5: return {{8{r[23]}}, r[23:16], {8{r[7]}}, r[7:0]};
      6: return {4{r[7:0]}};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0] ln;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R11 cout_valid in reset", 576'(cout_valid), 576'(0));
    chk("R11 dout_valid in reset", 576'(dout_valid), 576'(0));
    rst_n = 1;
    @(negedge clk);

    // R1: all-zero line
    do_compress('0, "zero line", 0);
    chk("R1 zero line one segment", 576'(cout_segs), 576'(1));
    do_expand('0, "zero line");

    // All ones: class 1 everywhere
    do_compress('1, "ones", 0);
    do_expand('1, "ones");

    // Directed mix touching every class and tie rules
    ln = '0;
    ln[32*0 +: 32] = 32'h0000_0000; ln[32*1 +: 32] = 32'h0000_0005;
    ln[32*2 +: 32] = 32'hFFFF_FFFD; ln[32*3 +: 32] = 32'h0000_007F;
    ln[32*4 +: 32] = 32'h5555_5555; ln[32*5 +: 32] = 32'h0000_1234;
    ln[32*6 +: 32] = 32'hABCD_0000; ln[32*7 +: 32] = 32'h007F_FF80;
    ln[32*8 +: 32] = 32'h1234_5678; ln[32*9 +: 32] = 32'hFFFF_8000;
    ln[32*10 +: 32] = 32'h8080_8080; ln[32*11 +: 32] = 32'h0001_0000;
    ln[32*12 +: 32] = 32'hFFFF_FF80; ln[32*13 +: 32] = 32'h0000_0008;
    ln[32*14 +: 32] = 32'h0101_0101; ln[32*15 +: 32] = 32'h0080_0000;
    do_compress(ln, "mixed classes", 3);
    do_expand(ln, "mixed classes");

    // R5: fully random words overflow into a raw line
    for (int i = 0; i < 16; i++) ln[32*i +: 32] = 32'h8000_0001 ^ (32'(i) << 20);
    do_compress(ln, "raw line", 0);
    chk("R5 raw line flagged", 576'(cout_raw), 576'(1));
    do_expand(ln, "raw line");

    // Constrained random lines
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < 16; i++) ln[32*i +: 32] = rand_word();
      do_compress(ln, "random", (k % 10 == 0) ? 2 : 0);
      do_expand(ln, "random");
    end

    // R10: stall the expander output
    ln = '0;
    for (int i = 0; i < 16; i++) ln[32*i +: 32] = 32'(i * 3) - 32'd20;
    do_compress(ln, "stall line", 0);
    @(negedge clk);
    din_prefix = c_pfx; din_payload = c_pl; din_raw = c_raw; din_valid = 1; dout_ready = 0;
    @(negedge clk);
    din_valid = 0;
    repeat (8) @(negedge clk);
    chk("R10 stalled valid", 576'(dout_valid), 576'(1));
    chk("R10 din_ready low", 576'(din_ready), 576'(0));
    chk("R10 stalled line", 576'(dout_line), 576'(ln));
    repeat (2) @(negedge clk);
    chk("R10 line still held", 576'(dout_line), 576'(ln));
    dout_ready = 1;
    @(negedge clk);
    chk("R10 drained", 576'(dout_valid), 576'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule